// File: doc/BRIEF.md
# Token-Counting Cache Line Permission Controller

This block keeps a token count for each of a small set of cache lines held by one node. Every line has a fixed total of tokens across the whole system. Read and write permission for a line are worked out from how many of those tokens the node holds right now. The node needs all of them to write and at least one to read. There is no coherence state machine and no directory lookup.

Tokens arrive from the interconnect as one-cycle messages that are always accepted. Because the count is simply a sum, the order in which messages arrive does not matter. Tokens leave through a request to give a number of them away. That request is passed on as an outgoing message on a valid/ready channel, but only if the line holds enough tokens. The count drops on the clock edge at which the outgoing message is accepted.

The processor side reports misses: a line that needs read or write permission it does not yet have. For each such line, a per-line starvation timer runs. If the miss is still unsatisfied after a set number of cycles, the block raises a one-cycle persistent-request start pulse for that line.

Top module: `tc_perm_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, every line holds zero tokens. All `rd_ok`, `wr_ok` and `persist_start` bits are 0, and `tx_valid` is 0 when no give request is presented.
- R2: A line holding all TOKENS tokens shows `rd_ok`=1 and `wr_ok`=1.
- R3: A line holding from 1 to TOKENS-1 tokens shows `rd_ok`=1 and `wr_ok`=0.
- R4: A line holding zero tokens shows `rd_ok`=0 and `wr_ok`=0.
- R5: A cycle with `rx_valid`=1 adds `rx_count` to line `rx_line`, and the result is visible after that clock edge. The final count depends only on the sum of the messages, not on their order.
- R6: A give request is forwarded: `tx_valid`=`give_valid`, `tx_line`=`give_line`, `tx_count`=`give_count`. The count of that line drops by `give_count` on an edge where `tx_valid` and `tx_ready` are both 1, and `give_ready` is 1 in exactly those cycles. So taking one token from a full line clears `wr_ok` right after that edge. If `tx_ready` is 0, the count stays unchanged.
- R7: `tx_valid` stays 0 when `give_count` is 0 or larger than the line's current count.
- R8: A miss (`miss_valid`, `miss_line`, `miss_write`=1 for write, 0 for read) registered at edge E0 that stays unsatisfied raises `persist_start` for that line for exactly one cycle, visible after edge E0+TIMEOUT. It does not repeat while the miss stays pending.
- R9: A pending miss is cleared, and its timer reset, on the edge at which the line gains the needed permission. No pulse follows, and a later miss times out TIMEOUT edges after it is registered.
- R10: A miss on a line that already has the requested permission starts no timer and raises no pulse.
- R11: If a receive and an accepted send hit the same line in one cycle, the line ends with the net count.
- R12: Token arrivals, sends and misses on one line leave the permissions and pulses of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Incoming token message present this cycle |
| rx_line | input | LW | Line index of the incoming tokens |
| rx_count | input | CW | Number of tokens arriving |
| give_valid | input | 1 | Request to send tokens away |
| give_line | input | LW | Line whose tokens are to be sent |
| give_count | input | CW | Number of tokens to send |
| give_ready | output | 1 | Give request taken this cycle |
| tx_valid | output | 1 | Outgoing token message valid |
| tx_line | output | LW | Line index of the outgoing tokens |
| tx_count | output | CW | Number of tokens leaving |
| tx_ready | input | 1 | Interconnect accepts the outgoing message |
| miss_valid | input | 1 | Processor reports a miss |
| miss_line | input | LW | Line of the miss |
| miss_write | input | 1 | 1 = write permission needed, 0 = read |
| rd_ok | output | NUM_LINES | Per-line read permission |
| wr_ok | output | NUM_LINES | Per-line write permission |
| persist_start | output | NUM_LINES | Per-line one-cycle persistent-request start pulse |

## Verification
The hardest thing to reach from the ports is the timer window. Two cases have to be told apart: a miss satisfied one or two cycles before its deadline, which must give no pulse, and a fresh miss after that, which must count from zero rather than from the old timer value. The stimulus raises a miss and counts edges exactly. It then delivers a token mid-window and watches the pulse output for more than a whole timeout. After that it drains the line and raises a new miss to check that the pulse lands on the precise edge. Cycles where a receive and an accepted send hit the same line together are driven on purpose, and they show up only in the permissions that follow.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef struct packed {
        logic rd;
        logic wr;
    } tc_perm_t;

    typedef enum logic {
        NEED_READ  = 1'b0,
        NEED_WRITE = 1'b1
    } tc_need_e;

    // Permission derived purely from the held count against the system total.
    function automatic tc_perm_t perm_of(input int unsigned held, input int unsigned total);
        tc_perm_t p;
        p.rd = (held != 0);
        p.wr = (held == total);
        return p;
    endfunction

    function automatic logic need_met(input tc_need_e need, input int unsigned held,
                                      input int unsigned total);
        tc_perm_t p;
        p = perm_of(held, total);
        return (need == NEED_WRITE) ? p.wr : p.rd;
    endfunction

endpackage

// File: rtl/tc_tx_gate.sv
module tc_tx_gate #(
    parameter int NUM_LINES = 4,
    parameter int LW = 2,
    parameter int CW = 3
) (
    input  logic          give_valid,
    input  logic [LW-1:0] give_line,
    input  logic [CW-1:0] give_count,
    input  logic [CW-1:0] held [NUM_LINES],
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic          give_ready,
    output logic [NUM_LINES-1:0] sub_en
);
    logic enough;

    always_comb begin
        enough     = (give_count != '0) && (held[give_line] >= give_count);
        tx_valid   = give_valid && enough;
        give_ready = tx_valid && tx_ready;
        for (int i = 0; i < NUM_LINES; i++) begin
            sub_en[i] = give_ready && (give_line == LW'(i));
        end
    end
endmodule

// File: rtl/tc_line_slot.sv
module tc_line_slot
    import tc_pkg::*;
#(
    parameter int TOKENS = 4,
    parameter int TIMEOUT = 16,
    parameter int CW = 3,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic [CW-1:0] add_cnt,
    input  logic          sub_en,
    input  logic [CW-1:0] sub_cnt,
    input  logic          miss_en,
    input  logic          miss_write,
    output logic [CW-1:0] held,
    output tc_perm_t      perm,
    output logic          persist
);
    logic [CW-1:0] held_q, held_n;
    logic [CW:0]   sum;
    logic          pend_q, pend_n;
    tc_need_e      need_q, need_n;
    logic [TW-1:0] timer_q, timer_n;
    logic          pulse_q, pulse_n;

    always_comb begin
        sum = {1'b0, held_q}
            + (add_en ? {1'b0, add_cnt} : '0)
            - (sub_en ? {1'b0, sub_cnt} : '0);
        held_n = (sum > (CW+1)'(TOKENS)) ? CW'(TOKENS) : sum[CW-1:0];

        if (miss_en) begin
            need_n = (miss_write || (pend_q && need_q == NEED_WRITE)) ? NEED_WRITE : NEED_READ;
        end else begin
            need_n = need_q;
        end
        pend_n = (pend_q || miss_en) && !need_met(need_n, int'(held_n), TOKENS);

        pulse_n = 1'b0;
        if (!pend_n || !pend_q) begin
            timer_n = '0;
        end else if (timer_q < TW'(TIMEOUT)) begin
            timer_n = timer_q + 1'b1;
            pulse_n = (timer_n == TW'(TIMEOUT));
        end else begin
            timer_n = timer_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            pend_q  <= 1'b0;
            need_q  <= NEED_READ;
            timer_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            held_q  <= held_n;
            pend_q  <= pend_n;
            need_q  <= need_n;
            timer_q <= timer_n;
            pulse_q <= pulse_n;
        end
    end

    assign held    = held_q;
    assign perm    = perm_of(int'(held_q), TOKENS);
    assign persist = pulse_q;
endmodule

// File: rtl/tc_perm_ctrl.sv
module tc_perm_ctrl
    import tc_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TOKENS = 4,
    parameter int TIMEOUT = 16,
    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int CW = $clog2(TOKENS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic [LW-1:0]        rx_line,
    input  logic [CW-1:0]        rx_count,
    input  logic                 give_valid,
    input  logic [LW-1:0]        give_line,
    input  logic [CW-1:0]        give_count,
    output logic                 give_ready,
    output logic                 tx_valid,
    output logic [LW-1:0]        tx_line,
    output logic [CW-1:0]        tx_count,
    input  logic                 tx_ready,
    input  logic                 miss_valid,
    input  logic [LW-1:0]        miss_line,
    input  logic                 miss_write,
    output logic [NUM_LINES-1:0] rd_ok,
    output logic [NUM_LINES-1:0] wr_ok,
    output logic [NUM_LINES-1:0] persist_start
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic [CW-1:0]        line_cnt [NUM_LINES];
    logic [NUM_LINES-1:0] sub_en;

    tc_tx_gate #(.NUM_LINES(NUM_LINES), .LW(LW), .CW(CW)) u_gate (
        .give_valid (give_valid),
        .give_line  (give_line),
        .give_count (give_count),
        .held       (line_cnt),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .give_ready (give_ready),
        .sub_en     (sub_en)
    );

    assign tx_line  = give_line;
    assign tx_count = give_count;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        tc_perm_t p;
        tc_line_slot #(.TOKENS(TOKENS), .TIMEOUT(TIMEOUT), .CW(CW), .TW(TW)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .add_en     (rx_valid && (rx_line == LW'(i))),
            .add_cnt    (rx_count),
            .sub_en     (sub_en[i]),
            .sub_cnt    (give_count),
            .miss_en    (miss_valid && (miss_line == LW'(i))),
            .miss_write (miss_write),
            .held       (line_cnt[i]),
            .perm       (p),
            .persist    (persist_start[i])
        );
        assign rd_ok[i] = p.rd;
        assign wr_ok[i] = p.wr;
    end
endmodule

// File: rtl/tc_perm_checker.sv
module tc_perm_checker #(
    parameter int NUM_LINES = 4,
    parameter int TOKENS = 4,
    parameter int LW = 2,
    parameter int CW = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_valid,
    input logic [LW-1:0]        rx_line,
    input logic [CW-1:0]        rx_count,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic [LW-1:0]        tx_line,
    input logic [CW-1:0]        tx_count,
    input logic [CW-1:0]        line_cnt [NUM_LINES],
    input logic [NUM_LINES-1:0] rd_ok,
    input logic [NUM_LINES-1:0] wr_ok,
    input logic [NUM_LINES-1:0] persist_start
);
    int unsigned rx_net;
    always_comb begin
        rx_net = int'(line_cnt[rx_line]) + int'(rx_count);
        if (tx_valid && tx_ready && tx_line == rx_line) rx_net = rx_net - int'(tx_count);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_net <= TOKENS); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |-> line_cnt[tx_line] >= tx_count); // R7

    AST_TX_HAS_TOKENS: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> rd_ok[tx_line]); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (rd_ok == '0 && wr_ok == '0 && persist_start == '0)); // R1

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (rst)
            wr_ok[i] |-> rd_ok[i]); // R2

        AST_SEND_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
            (tx_valid && tx_ready && tx_line == LW'(i) && !(rx_valid && rx_line == LW'(i)))
            |=> !wr_ok[i]); // R6

        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            persist_start[i] |=> !persist_start[i]); // R8
    end
endmodule

bind tc_perm_ctrl tc_perm_checker #(
    .NUM_LINES(NUM_LINES), .TOKENS(TOKENS), .LW(LW), .CW(CW)
) u_tc_perm_checker (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_line(rx_line), .rx_count(rx_count),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line), .tx_count(tx_count),
    .line_cnt(line_cnt), .rd_ok(rd_ok), .wr_ok(wr_ok), .persist_start(persist_start)
);

// File: tb/test_tc_perm_ctrl.sv
`timescale 1ns/1ps
module test_tc_perm_ctrl;
    localparam int NL = 4;
    localparam int TK = 4;
    localparam int TO = 6;
    localparam int LW = 2;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, give_valid = 0, tx_ready = 0, miss_valid = 0, miss_write = 0;
    logic [LW-1:0] rx_line = '0, give_line = '0, miss_line = '0;
    logic [CW-1:0] rx_count = '0, give_count = '0;
    logic give_ready, tx_valid;
    logic [LW-1:0] tx_line;
    logic [CW-1:0] tx_count;
    logic [NL-1:0] rd_ok, wr_ok, persist_start;

    int checks = 0;
    int errors = 0;
    int mcnt [NL];

    always #2 clk = ~clk;

    tc_perm_ctrl #(.NUM_LINES(NL), .TOKENS(TK), .TIMEOUT(TO)) i_tc_perm_ctrl (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_line(rx_line), .rx_count(rx_count),
        .give_valid(give_valid), .give_line(give_line), .give_count(give_count),
        .give_ready(give_ready), .tx_valid(tx_valid), .tx_line(tx_line), .tx_count(tx_count),
        .tx_ready(tx_ready), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_write(miss_write), .rd_ok(rd_ok), .wr_ok(wr_ok), .persist_start(persist_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_perms(input string req);
        for (int i = 0; i < NL; i++) begin
            int exp;
            int act;
            exp = ((mcnt[i] == TK) ? 2 : 0) + ((mcnt[i] != 0) ? 1 : 0);
            act = (wr_ok[i] ? 2 : 0) + (rd_ok[i] ? 1 : 0);
            chk(act == exp, req, act, exp);
        end
    endtask

    task automatic add_tok(input int l, input int n);
        rx_valid = 1; rx_line = LW'(l); rx_count = CW'(n);
        step();
        rx_valid = 0;
        mcnt[l] += n;
    endtask

    task automatic give(input int l, input int g, input bit rdy, input string req);
        bit expv;
        give_valid = 1; give_line = LW'(l); give_count = CW'(g); tx_ready = rdy;
        #1;
        expv = (g > 0) && (g <= mcnt[l]);
        chk(tx_valid == expv, req, int'(tx_valid), int'(expv));
        chk(give_ready == (expv && rdy), req, int'(give_ready), int'(expv && rdy));
        if (expv) chk(tx_line == LW'(l) && tx_count == CW'(g), req, int'(tx_count), g);
        step();
        give_valid = 0; tx_ready = 0;
        if (expv && rdy) mcnt[l] -= g;
    endtask

    task automatic drain(input int l);
        if (mcnt[l] > 0) give(l, mcnt[l], 1'b1, "R6");
    endtask

    task automatic miss(input int l, input bit w);
        miss_valid = 1; miss_line = LW'(l); miss_write = w;
        step();
        miss_valid = 0; miss_write = 0;
    endtask

    task automatic watch_pulse(input int l, input int fire_at, input int span, input string req);
        for (int k = 1; k <= span; k++) begin
            logic [NL-1:0] exp;
            step();
            exp = '0;
            if (k == fire_at) exp[l] = 1'b1;
            chk(persist_start == exp, req, int'(persist_start), int'(exp));
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) mcnt[i] = 0;
        step(); step();
        chk(rd_ok == '0 && wr_ok == '0, "R1", int'(rd_ok), 0);
        chk(persist_start == '0 && tx_valid == 0, "R1", int'(persist_start), 0);
        rst = 0;
        step();
        check_perms("R1");
        chk(persist_start == '0, "R1", int'(persist_start), 0);

        // R2 R3 R4 R12: one token at a time on each line
        for (int l = 0; l < NL; l++) begin
            check_perms("R4");
            for (int c = 1; c <= TK; c++) begin
                add_tok(l, 1);
                check_perms((c == TK) ? "R2" : "R3");
            end
            drain(l);
            check_perms("R12");
        end

        // R7 R6: every held count against every give size, ready low then high
        for (int c = 0; c <= TK; c++) begin
            for (int g = 0; g <= TK; g++) begin
                if (c > 0) add_tok(2, c);
                give(2, g, 1'b0, "R6");
                check_perms("R6");
                give(2, g, 1'b1, "R7");
                check_perms("R7");
                drain(2);
            end
        end

        // R5: several arrival orders, same sum
        add_tok(1, 1); add_tok(1, 3); check_perms("R5"); drain(1);
        add_tok(1, 3); add_tok(1, 1); check_perms("R5"); drain(1);
        add_tok(1, 2); add_tok(1, 1); check_perms("R5"); add_tok(1, 1); check_perms("R5"); drain(1);
        add_tok(1, 1); add_tok(1, 1); add_tok(1, 2); check_perms("R5"); drain(1);

        // R6: one token away from a full line drops write at once
        add_tok(0, 4);
        give(0, 1, 1'b1, "R6");
        chk(wr_ok[0] == 0 && rd_ok[0] == 1, "R6", int'(wr_ok[0]), 0);
        drain(0);

        // R11: receive and send on one line in the same cycle
        add_tok(0, 2);
        rx_valid = 1; rx_line = 0; rx_count = 2;
        give(0, 1, 1'b1, "R11");
        rx_valid = 0; mcnt[0] += 2;
        check_perms("R11");
        rx_valid = 1; rx_line = 0; rx_count = 1;
        give(0, 3, 1'b1, "R11");
        rx_valid = 0; mcnt[0] += 1;
        check_perms("R11");
        drain(0);

        // R8: unsatisfied read miss, single pulse at TO, no repeat
        miss(1, 1'b0);
        watch_pulse(1, TO, TO + 3, "R8");
        add_tok(1, 1);
        check_perms("R8");
        // R8: write miss with partial tokens
        miss(1, 1'b1);
        watch_pulse(1, TO, TO + 2, "R8");
        add_tok(1, 3);
        check_perms("R8");
        drain(1);

        // R9: satisfied before deadline, then a fresh miss
        miss(3, 1'b0);
        watch_pulse(3, 0, 2, "R9");
        add_tok(3, 1);
        watch_pulse(3, 0, TO + 2, "R9");
        drain(3);
        miss(3, 1'b0);
        watch_pulse(3, TO, TO + 1, "R9");
        add_tok(3, 1);
        drain(3);

        // R10: miss on a line that already has permission
        add_tok(2, 4);
        miss(2, 1'b1);
        watch_pulse(2, 0, TO + 2, "R10");
        drain(2);
        add_tok(0, 1);
        miss(0, 1'b0);
        watch_pulse(0, 0, TO + 2, "R10");
        drain(0);
        check_perms("R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule